// File: doc/BRIEF.md
# J1850 Protocol Timebase and Break Generator

This block sits at the front of a J1850 bus controller and supplies its time reference. A system-clock prescaler, set by an 8-bit rate value, produces a single-cycle protocol tick every R+1 clocks, aiming for about 1 MHz. An enable bit in an 8-bit control register starts and stops the tick. While the block is disabled the tick is held off to save power, but both registers can still be read and written.

Setting the break bit while also setting the enable bit starts a BREAK symbol straight away. The bus output goes to the dominant level for a fixed number of protocol ticks. A one-cycle abort pulse tells the local transmitter to give up whatever it is sending. The break bit clears itself two system clocks after it is written.

Top module: `j1850_timebase`

## Requirements
- R1: After reset, both register readbacks are 0, and `tick`, `bus_break` and `tx_abort` are 0.
- R2: The control readback has enable at bit 4 and break at bit 0, with every other bit 0. A write takes effect on the next clock and is accepted whether or not the block is enabled.
- R3: A rate write stores the 8-bit value, and `rate_rdata` shows it on the next clock.
- R4: While enable is 0, `tick` stays 0.
- R5: While enable is 1 and the rate is R, `tick` is a one-cycle pulse repeating every R+1 clocks. With R = 0 it is high on every clock.
- R6: A control write with bit 0 set makes bit 0 read 1 for exactly two clocks, after which it reads 0 again without any further write.
- R7: A control write that sets both bit 4 and bit 0 drives `bus_break` high from the next clock. It stays high for exactly BREAK_TICKS×(R+1) clocks, because the prescaler restarts at the command. The length counts raw prescaler ticks, so it is the same at either bus speed.
- R8: `tx_abort` is high for one clock with each accepted break command, in the same clock in which `bus_break` first rises.
- R9: A break command written with bit 4 clear does not start a BREAK and does not raise `tx_abort`. Bit 0 still self-clears as in R6.
- R10: A break command accepted while a BREAK is running restarts the full length from the new command.
- R11: A control write with bit 4 clear ends a running BREAK on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Write strobe for the control register |
| rate_we | input | 1 | Write strobe for the rate register |
| wdata | input | 8 | Write data shared by both registers |
| ctl_rdata | output | 8 | Control register readback |
| rate_rdata | output | 8 | Rate register readback |
| tick | output | 1 | Protocol tick pulse |
| bus_break | output | 1 | Bus drive; 1 means dominant, high during a BREAK |
| tx_abort | output | 1 | One-cycle abort pulse for the local transmitter |

## Verification
The hardest state to reach from the ports is a second break command that lands partway through a running BREAK. A restart has to cancel both the tick count and the prescaler phase, and a length measured only from the first command would hide a missing restart. The stimulus therefore issues one command and waits several hundred clocks. It then issues a second command and measures the high time from there, and also ends one BREAK early with a disabling write. A cycle-level model in the bench tracks the remaining break clocks as a single countdown, and every output is compared against it on each clock.

// File: rtl/j1850_timebase.sv
module j1850_timebase #(
  parameter int REG_W       = 8,
  parameter int EN_BIT      = 4,
  parameter int BRK_BIT     = 0,
  parameter int BREAK_TICKS = 280
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic             rate_we,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] ctl_rdata,
  output logic [REG_W-1:0] rate_rdata,
  output logic             tick,
  output logic             bus_break,
  output logic             tx_abort
);
  localparam int BCNT_W = $clog2(BREAK_TICKS + 1);
  localparam logic [BCNT_W-1:0] LAST_TICK = BCNT_W'(BREAK_TICKS - 1);

  logic             en_q, brk_q, brk_age;
  logic [REG_W-1:0] rate_q, div_cnt;
  logic [BCNT_W-1:0] brk_ticks;

  wire start = ctl_we & wdata[EN_BIT] & wdata[BRK_BIT];
  wire stop  = ctl_we & ~wdata[EN_BIT];

  assign tick       = en_q && (div_cnt == rate_q);
  assign rate_rdata = rate_q;

  always_comb begin
    ctl_rdata          = '0;
    ctl_rdata[EN_BIT]  = en_q;
    ctl_rdata[BRK_BIT] = brk_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      brk_q   <= 1'b0;
      brk_age <= 1'b0;
    end else if (ctl_we) begin
      en_q    <= wdata[EN_BIT];
      brk_q   <= wdata[BRK_BIT];
      brk_age <= 1'b0;
    end else if (brk_q) begin
      brk_age <= 1'b1;
      if (brk_age) brk_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rate_q <= '0;
    else if (rate_we) rate_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 div_cnt <= '0;
    else if (!en_q || start)    div_cnt <= '0;
    else if (div_cnt >= rate_q) div_cnt <= '0;
    else                        div_cnt <= div_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_break <= 1'b0;
      brk_ticks <= '0;
      tx_abort  <= 1'b0;
    end else begin
      tx_abort <= start;
      if (start) begin
        bus_break <= 1'b1;
        brk_ticks <= '0;
      end else if (stop) begin
        bus_break <= 1'b0;
      end else if (bus_break && tick) begin
        brk_ticks <= brk_ticks + 1'b1;
        if (brk_ticks == LAST_TICK) bus_break <= 1'b0;
      end
    end
  end

  // R4
  tick_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_rdata[EN_BIT] |-> !tick);

  // R7
  break_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> bus_break && tx_abort);

  // R8
  abort_in_break_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_abort |-> bus_break);

  // R11
  break_end_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_break) |-> $past(tick) || $past(ctl_we));

  // R6
  brk_selfclear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rdata[BRK_BIT] && $past(ctl_rdata[BRK_BIT]) && !$past(ctl_we) && !ctl_we
    |=> !ctl_rdata[BRK_BIT]);

  // R9
  no_break_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we && !wdata[EN_BIT] |=> !bus_break && !tx_abort);
endmodule

// File: tb/j1850_timebase_bench.sv
module j1850_timebase_bench;
  localparam int BT = 280;

  logic       clk = 1'b0, rst_n = 1'b0, ctl_we = 1'b0, rate_we = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] ctl_rdata, rate_rdata;
  logic       tick, bus_break, tx_abort;

  j1850_timebase #(.BREAK_TICKS(BT)) u_j1850_timebase (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .rate_we(rate_we), .wdata(wdata),
    .ctl_rdata(ctl_rdata), .rate_rdata(rate_rdata), .tick(tick),
    .bus_break(bus_break), .tx_abort(tx_abort));

  always #5 clk = ~clk;

  int checks = 0, errors = 0, cycles = 0;
  string tag = "R1";

  bit m_en, m_brk, m_abort;
  int m_age, m_rate, m_phase, m_left;

  function automatic bit m_tick();
    return m_en && ((m_phase % (m_rate + 1)) == m_rate);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_brk = 0; m_age = 0; m_rate = 0; m_phase = 0; m_left = 0; m_abort = 0;
    end else begin
      bit st, sp;
      st = ctl_we && wdata[4] && wdata[0];
      sp = ctl_we && !wdata[4];
      if (st) m_left = BT * (m_rate + 1);
      else if (sp) m_left = 0;
      else if (m_left > 0) m_left--;
      m_abort = st;
      m_phase = (!m_en || st) ? 0 : m_phase + 1;
      if (ctl_we) begin m_en = wdata[4]; m_brk = wdata[0]; m_age = 0; end
      else if (m_brk) begin if (m_age == 1) m_brk = 0; m_age++; end
      if (rate_we) m_rate = wdata;
    end
  end

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", req, cycles, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      chk({"R4/R5 tick ", tag}, {7'd0, tick}, {7'd0, m_tick()});
      chk({"R7 bus_break ", tag}, {7'd0, bus_break}, {7'd0, m_left > 0});
      chk({"R8 tx_abort ", tag}, {7'd0, tx_abort}, {7'd0, m_abort});
      chk({"R2/R6 ctl_rdata ", tag}, ctl_rdata, {3'b0, m_en, 3'b0, m_brk});
      chk({"R3 rate_rdata ", tag}, rate_rdata, 8'(m_rate));
    end
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected under 100000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic idle(int n); repeat (n) @(negedge clk); endtask
  task automatic wr_ctl(logic [7:0] v);
    @(negedge clk); ctl_we = 1'b1; wdata = v; @(negedge clk); ctl_we = 1'b0;
  endtask
  task automatic wr_rate(logic [7:0] v);
    @(negedge clk); rate_we = 1'b1; wdata = v; @(negedge clk); rate_we = 1'b0;
  endtask
  task automatic measure(output int len);
    len = 0;
    while (bus_break) begin len++; @(negedge clk); end
  endtask

  initial begin
    int len;
    idle(3); rst_n = 1'b1;
    @(negedge clk);
    tag = "R1";
    chk("R1 reset outputs", {ctl_rdata[7:1] , tick ^ bus_break ^ tx_abort}, 8'h00);
    tag = "R3"; wr_rate(8'h02); chk("R3 rate readback", rate_rdata, 8'h02);
    tag = "R4"; idle(10);
    tag = "R5"; wr_ctl(8'h10); idle(30);
    tag = "R2"; wr_ctl(8'h00); wr_rate(8'h00); wr_ctl(8'h10); idle(8);
    tag = "R7"; wr_ctl(8'h11); measure(len); chk("R7 length R=0", 8'(len == BT), 8'h01);
    idle(5);
    wr_ctl(8'h00); wr_rate(8'h02); wr_ctl(8'h10); idle(4);
    wr_ctl(8'h11); measure(len); chk("R7 length R=2", 8'(len == BT * 3), 8'h01);
    tag = "R10"; idle(2); wr_ctl(8'h11); idle(400); wr_ctl(8'h11); measure(len);
    chk("R10 restart length", 8'(len == BT * 3), 8'h01);
    tag = "R11"; idle(2); wr_ctl(8'h11); idle(50); wr_ctl(8'h00); idle(1);
    chk("R11 break ended", {7'd0, bus_break}, 8'h00);
    tag = "R9"; wr_ctl(8'h01); chk("R9 no abort", {7'd0, tx_abort}, 8'h00); idle(3);
    chk("R9 no break", {7'd0, bus_break}, 8'h00);
    chk("R9/R6 bit cleared", ctl_rdata, 8'h00);
    tag = "R2"; wr_ctl(8'hFF); chk("R2 unused bits zero", ctl_rdata, 8'h11);
    idle(1); wr_ctl(8'h10); idle(5);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule